// File: doc/BRIEF.md
# Fast System Call Entry Sequencer

This block performs the privileged state change for a fast system-call instruction in a processor core. When a start strobe arrives, it samples the current instruction pointer, the instruction length, the flags and the mode bits. It also samples the target, alternate-target, compat-target and flag-mask configuration values. From these it computes the values the core commits: the new instruction pointer, the saved return pointer, the saved flags, the new flags, and flat code and stack segment selectors with their attributes.

Two datapaths exist. The wide-mode path saves a full 64-bit return pointer and a copy of the flags, masks the flags with a programmable mask, and picks one of two target registers by the caller's code width. The legacy path saves a 32-bit return pointer, clears a fixed set of flags, and jumps to the low half of the main target register. If the feature-enable input is low, the block raises an invalid-opcode fault and leaves its outputs as they were.

Top module: `sysent_seq`

## Requirements
- R1: When start_i is high and enable_i is low, fault_o pulses one cycle later and commit_o stays low. In that cycle every data output keeps its previous value.
- R2: On commit, cs_sel_o equals target_i[47:32] with bits 1:0 forced to zero.
- R3: On commit, ss_sel_o equals (target_i[47:32] + 8) modulo 2^16 with bits 1:0 forced to zero.
- R4: On commit, flat_base_o is 0 and flat_limit_o is 0xFFFFFFFF. The attribute byte is {bit7 granularity, bit6 default size, bit5 64-bit code, bit4 present, bit3 code/data, bit2 executable, bit1 read/write, bit0 accessed}. ss_attr_o is 0xDB in both modes.
- R5: In wide mode (wide_i=1), ret_ptr_o = ip_i + ilen_i over 64 bits, save_flags_o = flags_i with bit 16 cleared, zero-extended, and save_we_o = 1.
- R6: In wide mode, flags_o = flags_i & ~fmask_i with bit 16 also cleared, and cs_attr_o = 0xBF.
- R7: In wide mode, ip_o = alt_tgt_i when code64_i = 1 and compat_tgt_i otherwise.
- R8: In legacy mode (wide_i=0), ret_ptr_o is the low 32 bits of ip_i + ilen_i, zero-extended. flags_o = flags_i with bits 9, 16 and 17 cleared. cs_attr_o = 0xDF. ip_o is target_i[31:0], zero-extended. save_we_o = 0, and save_flags_o keeps its previous value.
- R9: For each cycle with start_i high, there is exactly one one-cycle pulse on the next cycle: commit_o when enable_i was high, fault_o otherwise. The two never rise together. With no start there is no pulse, and outputs hold between starts.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; operands are sampled on this edge |
| enable_i | input | 1 | Fast-call feature enable |
| wide_i | input | 1 | Wide (64-bit) mode active |
| code64_i | input | 1 | Caller runs 64-bit code |
| ip_i | input | 64 | Current instruction pointer |
| ilen_i | input | 4 | Instruction length |
| flags_i | input | 32 | Current flags |
| target_i | input | 64 | Selector base [47:32] and legacy target [31:0] |
| alt_tgt_i | input | 64 | Wide-mode target for 64-bit callers |
| compat_tgt_i | input | 64 | Wide-mode target for compat callers |
| fmask_i | input | 32 | Wide-mode flag clear mask |
| commit_o | output | 1 | Successful completion pulse |
| fault_o | output | 1 | Invalid-opcode fault pulse |
| ip_o | output | 64 | New instruction pointer |
| ret_ptr_o | output | 64 | Saved return pointer |
| save_flags_o | output | 64 | Saved flags value |
| save_we_o | output | 1 | save_flags_o was written by the last commit |
| flags_o | output | 32 | New flags |
| cs_sel_o | output | 16 | Code segment selector |
| ss_sel_o | output | 16 | Stack segment selector |
| cs_attr_o | output | 8 | Code segment attributes |
| ss_attr_o | output | 8 | Stack segment attributes |
| flat_base_o | output | 64 | Base of both segments |
| flat_limit_o | output | 32 | Limit of both segments |

## Verification
The overlap that needs care is the result pulse of one request landing in the same cycle as the capture of the next. This matters most when a fault follows a commit, or a commit follows a fault, with no gap. The bench drives back-to-back starts while toggling enable_i and the mode bits, so each pulse and its held outputs sit next to a differently typed neighbour. A behavioural model updated on every clock judges each cycle. It checks that the fault cycle leaves the previous commit's values untouched and that only one pulse type appears.

// File: rtl/sysent_pkg.sv
package sysent_pkg;
  localparam int FL_IF = 9;
  localparam int FL_RF = 16;
  localparam int FL_VM = 17;
  localparam int SEL_STEP = 8;

  typedef struct packed {
    logic gran;
    logic dflt;
    logic lng;
    logic pres;
    logic sys;
    logic code;
    logic rw;
    logic acc;
  } seg_attr_t;

  localparam seg_attr_t ATTR_CS_WIDE = '{gran: 1'b1, dflt: 1'b0, lng: 1'b1, pres: 1'b1,
                                         sys: 1'b1, code: 1'b1, rw: 1'b1, acc: 1'b1};
  localparam seg_attr_t ATTR_CS_LEG  = '{gran: 1'b1, dflt: 1'b1, lng: 1'b0, pres: 1'b1,
                                         sys: 1'b1, code: 1'b1, rw: 1'b1, acc: 1'b1};
  localparam seg_attr_t ATTR_SS      = '{gran: 1'b1, dflt: 1'b1, lng: 1'b0, pres: 1'b1,
                                         sys: 1'b1, code: 1'b0, rw: 1'b1, acc: 1'b1};
endpackage

// File: rtl/sysent_sel.sv
module sysent_sel #(
  parameter int SELW = 16
) (
  input  logic [SELW-1:0] base_i,
  output logic [SELW-1:0] cs_sel_o,
  output logic [SELW-1:0] ss_sel_o
);
  import sysent_pkg::*;
  localparam logic [SELW-1:0] RPL_CLR = ~SELW'(3);
  logic [SELW-1:0] ss_raw;

  always_comb begin
    ss_raw   = base_i + SELW'(SEL_STEP);
    cs_sel_o = base_i & RPL_CLR;
    ss_sel_o = ss_raw & RPL_CLR;
  end
endmodule

// File: rtl/sysent_flags.sv
module sysent_flags #(
  parameter int FLAGW = 32,
  parameter int XLEN  = 64
) (
  input  logic             wide_i,
  input  logic [FLAGW-1:0] flags_i,
  input  logic [FLAGW-1:0] fmask_i,
  output logic [FLAGW-1:0] new_flags_o,
  output logic [XLEN-1:0]  saved_o
);
  import sysent_pkg::*;
  localparam logic [FLAGW-1:0] RF_BIT  = FLAGW'(1) << FL_RF;
  localparam logic [FLAGW-1:0] LEG_CLR = (FLAGW'(1) << FL_IF) | (FLAGW'(1) << FL_RF)
                                       | (FLAGW'(1) << FL_VM);
  logic [FLAGW-1:0] clr;

  always_comb begin
    clr         = wide_i ? (fmask_i | RF_BIT) : LEG_CLR;
    new_flags_o = flags_i & ~clr;
    saved_o     = XLEN'(flags_i & ~RF_BIT);
  end
endmodule

// File: rtl/sysent_tgt.sv
module sysent_tgt #(
  parameter int XLEN  = 64,
  parameter int ILENW = 4
) (
  input  logic             wide_i,
  input  logic             code64_i,
  input  logic [XLEN-1:0]  ip_i,
  input  logic [ILENW-1:0] ilen_i,
  input  logic [XLEN-1:0]  target_i,
  input  logic [XLEN-1:0]  alt_tgt_i,
  input  logic [XLEN-1:0]  compat_tgt_i,
  output logic [XLEN-1:0]  next_ip_o,
  output logic [XLEN-1:0]  ret_o
);
  logic [XLEN-1:0] nxt;

  always_comb begin
    nxt = ip_i + XLEN'(ilen_i);
    if (wide_i) begin
      ret_o     = nxt;
      next_ip_o = code64_i ? alt_tgt_i : compat_tgt_i;
    end else begin
      ret_o     = XLEN'(nxt[31:0]);
      next_ip_o = XLEN'(target_i[31:0]);
    end
  end
endmodule

// File: rtl/sysent_seq.sv
module sysent_seq #(
  parameter int XLEN  = 64,
  parameter int FLAGW = 32,
  parameter int ILENW = 4,
  parameter int SELW  = 16,
  parameter int SEL_LSB = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             enable_i,
  input  logic             wide_i,
  input  logic             code64_i,
  input  logic [XLEN-1:0]  ip_i,
  input  logic [ILENW-1:0] ilen_i,
  input  logic [FLAGW-1:0] flags_i,
  input  logic [XLEN-1:0]  target_i,
  input  logic [XLEN-1:0]  alt_tgt_i,
  input  logic [XLEN-1:0]  compat_tgt_i,
  input  logic [FLAGW-1:0] fmask_i,
  output logic             commit_o,
  output logic             fault_o,
  output logic [XLEN-1:0]  ip_o,
  output logic [XLEN-1:0]  ret_ptr_o,
  output logic [XLEN-1:0]  save_flags_o,
  output logic             save_we_o,
  output logic [FLAGW-1:0] flags_o,
  output logic [SELW-1:0]  cs_sel_o,
  output logic [SELW-1:0]  ss_sel_o,
  output logic [7:0]       cs_attr_o,
  output logic [7:0]       ss_attr_o,
  output logic [XLEN-1:0]  flat_base_o,
  output logic [31:0]      flat_limit_o
);
  import sysent_pkg::*;

  logic [SELW-1:0]  cs_sel_d, ss_sel_d;
  logic [FLAGW-1:0] flags_d;
  logic [XLEN-1:0]  saved_d, ip_d, ret_d;
  logic             go, bad;

  assign go  = start_i & enable_i;
  assign bad = start_i & ~enable_i;

  sysent_sel #(.SELW(SELW)) u_sel (
    .base_i   (target_i[SEL_LSB +: SELW]),
    .cs_sel_o (cs_sel_d),
    .ss_sel_o (ss_sel_d)
  );

  sysent_flags #(.FLAGW(FLAGW), .XLEN(XLEN)) u_flags (
    .wide_i      (wide_i),
    .flags_i     (flags_i),
    .fmask_i     (fmask_i),
    .new_flags_o (flags_d),
    .saved_o     (saved_d)
  );

  sysent_tgt #(.XLEN(XLEN), .ILENW(ILENW)) u_tgt (
    .wide_i       (wide_i),
    .code64_i     (code64_i),
    .ip_i         (ip_i),
    .ilen_i       (ilen_i),
    .target_i     (target_i),
    .alt_tgt_i    (alt_tgt_i),
    .compat_tgt_i (compat_tgt_i),
    .next_ip_o    (ip_d),
    .ret_o        (ret_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      commit_o <= go;
      fault_o  <= bad;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_o         <= '0;
      ret_ptr_o    <= '0;
      save_flags_o <= '0;
      save_we_o    <= 1'b0;
      flags_o      <= '0;
      cs_sel_o     <= '0;
      ss_sel_o     <= '0;
      cs_attr_o    <= '0;
      ss_attr_o    <= '0;
      flat_base_o  <= '0;
      flat_limit_o <= '0;
    end else if (go) begin
      ip_o         <= ip_d;
      ret_ptr_o    <= ret_d;
      save_we_o    <= wide_i;
      if (wide_i) save_flags_o <= saved_d;
      flags_o      <= flags_d;
      cs_sel_o     <= cs_sel_d;
      ss_sel_o     <= ss_sel_d;
      cs_attr_o    <= wide_i ? ATTR_CS_WIDE : ATTR_CS_LEG;
      ss_attr_o    <= ATTR_SS;
      flat_base_o  <= '0;
      flat_limit_o <= '1;
    end
  end

  a_r9_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && fault_o));
  a_r9_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (commit_o || fault_o));
  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !(commit_o || fault_o));
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($stable(ip_o) && $stable(flags_o) && $stable(ret_ptr_o) && $stable(cs_sel_o)));
  a_r2_rpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> cs_sel_o[1:0] == 2'b00);
  a_r3_ss_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> ss_sel_o == SELW'(cs_sel_o + SELW'(SEL_STEP)));
  a_r5_rf_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !flags_o[FL_RF]);
  a_r8_if_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && !save_we_o) |-> (!flags_o[FL_IF] && !flags_o[FL_VM]));
endmodule

// File: tb/sim_sysent_seq.sv
module sim_sysent_seq;
  localparam int PERIOD = 10;
  localparam int WDOG   = 20000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, en = 0, wide = 0, c64 = 0;
  logic [63:0] ip = 0, tgt = 0, alt = 0, cmp = 0;
  logic [3:0]  ilen = 0;
  logic [31:0] fl = 0, fm = 0;

  logic        commit, fault, swe;
  logic [63:0] ip_o, ret_o, sfl_o, base_o;
  logic [31:0] fl_o, lim_o;
  logic [15:0] css, sss;
  logic [7:0]  csa, ssa;

  int checks = 0, fails = 0, cyc = 0;
  bit  done_run = 0;

  sysent_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .enable_i(en), .wide_i(wide),
    .code64_i(c64), .ip_i(ip), .ilen_i(ilen), .flags_i(fl), .target_i(tgt),
    .alt_tgt_i(alt), .compat_tgt_i(cmp), .fmask_i(fm),
    .commit_o(commit), .fault_o(fault), .ip_o(ip_o), .ret_ptr_o(ret_o),
    .save_flags_o(sfl_o), .save_we_o(swe), .flags_o(fl_o), .cs_sel_o(css),
    .ss_sel_o(sss), .cs_attr_o(csa), .ss_attr_o(ssa), .flat_base_o(base_o),
    .flat_limit_o(lim_o)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic        m_com, m_flt, m_swe;
  logic [63:0] m_ip, m_ret, m_sfl, m_base;
  logic [31:0] m_fl, m_lim;
  logic [15:0] m_css, m_sss;
  logic [7:0]  m_csa, m_ssa;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_com = 0; m_flt = 0; m_swe = 0; m_ip = 0; m_ret = 0; m_sfl = 0; m_base = 0;
      m_fl = 0; m_lim = 0; m_css = 0; m_sss = 0; m_csa = 0; m_ssa = 0;
    end else begin
      m_com = start && en;
      m_flt = start && !en;
      if (m_com) begin
        logic [15:0] b;
        logic [63:0] nx;
        b = tgt[47:32];
        m_css = {b[15:2], 2'b00};
        m_sss = b + 16'd8;
        m_sss[1:0] = 2'b00;
        m_ssa = 8'hDB; m_base = 0; m_lim = 32'hFFFF_FFFF;
        nx = ip + {60'd0, ilen};
        if (wide) begin
          m_ret = nx;
          m_sfl = {32'd0, fl & ~32'h0001_0000};
          m_swe = 1;
          m_fl  = fl & ~fm & ~32'h0001_0000;
          m_csa = 8'hBF;
          m_ip  = c64 ? alt : cmp;
        end else begin
          m_ret = {32'd0, nx[31:0]};
          m_swe = 0;
          m_fl  = fl & ~32'h0003_0200;
          m_csa = 8'hDF;
          m_ip  = {32'd0, tgt[31:0]};
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      chk("R9", "commit", {63'd0, commit}, {63'd0, m_com});
      chk("R1", "fault", {63'd0, fault}, {63'd0, m_flt});
      chk("R7", "ip", ip_o, m_ip);
      chk("R5", "ret_ptr", ret_o, m_ret);
      chk("R5", "save_flags", sfl_o, m_sfl);
      chk("R8", "save_we", {63'd0, swe}, {63'd0, m_swe});
      chk("R6", "flags", {32'd0, fl_o}, {32'd0, m_fl});
      chk("R2", "cs_sel", {48'd0, css}, {48'd0, m_css});
      chk("R3", "ss_sel", {48'd0, sss}, {48'd0, m_sss});
      chk("R4", "attrs", {48'd0, csa, ssa}, {48'd0, m_csa, m_ssa});
      chk("R4", "base_limit", base_o ^ {32'd0, lim_o}, m_base ^ {32'd0, m_lim});
    end
  end

  task automatic summary();
    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done_run) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WDOG);
      summary();
    end
  end

  task automatic req(input bit e, input bit w, input bit c, input logic [63:0] t);
    @(negedge clk);
    start = 1; en = e; wide = w; c64 = c; tgt = t;
    ip = {$urandom, $urandom}; ilen = 4'($urandom);
    fl = $urandom; fm = $urandom;
    alt = {$urandom, $urandom}; cmp = {$urandom, $urandom};
  endtask

  task automatic idle();
    @(negedge clk);
    start = 0;
    ip = {$urandom, $urandom}; fl = $urandom;
  endtask

  initial begin
    #(PERIOD*2 + 1);
    // R10: reset values
    chk("R10", "ip", ip_o, 0);
    chk("R10", "flags", {32'd0, fl_o}, 0);
    chk("R10", "pulses", {62'd0, commit, fault}, 0);
    chk("R10", "attrs", {48'd0, csa, ssa}, 0);
    rst_n = 1;
    idle(); idle();
    for (int i = 0; i < 40; i++) req(1, 1, 1, {$urandom, $urandom});
    idle();
    for (int i = 0; i < 40; i++) req(1, 1, 0, {$urandom, $urandom});
    idle();
    for (int i = 0; i < 40; i++) req(1, 0, 0, {$urandom, $urandom});
    idle();
    // R1: faults in isolation and after commits
    req(1, 1, 1, {$urandom, $urandom});
    req(0, 1, 1, {$urandom, $urandom});
    req(0, 0, 0, {$urandom, $urandom});
    idle(); idle();
    // R3: selector wrap boundaries
    req(1, 1, 1, 64'h0000_FFFA_1234_5678);
    req(1, 0, 0, 64'h0000_FFF8_0000_0001);
    req(1, 1, 0, 64'h0000_0003_FFFF_FFFF);
    // R8: legacy truncation of return pointer
    @(negedge clk);
    start = 1; en = 1; wide = 0; ip = 64'h1234_5678_FFFF_FFFE; ilen = 4'd5;
    fl = 32'hFFFF_FFFF; tgt = 64'hABCD_0010_8000_0000;
    idle();
    // R9: mixed back-to-back stream
    for (int i = 0; i < 200; i++) begin
      if ($urandom % 4 == 0) idle();
      else req(1'($urandom), 1'($urandom), 1'($urandom), {$urandom, $urandom});
    end
    idle(); idle(); idle();
    summary();
  end
endmodule